// File: doc/BRIEF.md
# Serial Loss-of-Signal Monitor

This block sits on a bit-serial receive path, with one clock edge per bit time. It looks for a long stretch in which the serial data never changes level. When it finds one, it raises a loss flag. It also drives a reference-select output, which tells a clock-recovery loop to lock to the local reference clock rather than to the data. An external force input squelches the data to a constant level and declares loss at the next evaluation point. The squelched stream is passed on as the data output.

A free-running 7-bit phase counter splits time into evaluation windows of 128 bit times. An activity flag is cleared at phase 32 and set by any transition. At phase 127 the flag is judged. Because the flag clears at a fixed phase, the time from the last transition to the declaration depends on where that transition fell. It ranges from 96 to 223 bit times. Recovery needs activity in two windows in a row with the force input low. Both outputs change only at phase 127.

Top module: `los_monitor`

## Requirements
- R1: While reset is held, and after it is released until the first evaluation point, `los_flag` is 1 and `ref_sel` is 1. The bit history used for edge detection resets to 0.
- R2: The window phase is the number of rising clock edges since reset release, modulo 128. A transition is a sampled bit that differs from the previous sampled bit of the squelched stream. Suppose `los_flag` is 0, the force input is low, and the last transition lands at phase c. Loss is then declared 127−c edges later for c < 32 and 255−c edges later for c ≥ 32. This gives 96 to 223 bit times.
- R3: With `force_los` at 1, `ser_out` is 0 whatever `ser_in` does. With `force_los` at 0, `ser_out` equals `ser_in`.
- R4: If `force_los` is 1 at the phase-127 edge, `los_flag` is 1 after that edge. Force applied at phase p therefore declares 127−p edges later, always within 128 bit times.
- R5: `ref_sel` is 1 (local reference) exactly when `los_flag` is 1, and 0 (data) otherwise.
- R6: `los_flag` and `ref_sel` change only at the edge where the phase is 127.
- R7: While loss is declared, the flag clears only after two consecutive windows that each contain at least one transition, with `force_los` low at both evaluation points. A window without a transition restarts the count. Holding `force_los` at 1 keeps the loss declared whatever `ser_in` does.
- R8: A window counts as active if it has a transition at any phase from 32 to 127 inclusive. A transition at phase 31 or earlier does not count for that window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock, one edge per serial bit |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Incoming serial data bit |
| force_los | input | 1 | External request to squelch data and declare loss |
| ser_out | output | 1 | Squelched serial data |
| los_flag | output | 1 | Loss-of-signal status, 1 = declared |
| ref_sel | output | 1 | Clock-recovery reference, 1 = local reference, 0 = data |

## Verification
The bench places the last transition at phases 0, 31, 32 and 127, the ends of the latency range. A design that clears the activity flag at the wrong phase, or judges it at the wrong point, misses 127, 96, 223 or 128 by a cycle or more. Single transitions at phases 31 and 32 test the window edge. An off-by-one in the clear point either keeps a dead line alive or declares a live one. Sequences of active, silent and active windows check that the recovery count restarts. Force tests check the squelch level, the exact force latency, and that loss cannot clear while force is held. A design that let force bypass the evaluation point, or let toggling data through the squelch, would fail these.

// File: rtl/los_mon_pkg.sv
`timescale 1ns/1ps
package los_mon_pkg;

  // reference-clock choice handed to the recovery loop
  typedef enum logic {
    SRC_DATA = 1'b0,
    SRC_LOCAL = 1'b1
  } ref_src_e;

  // bit times from the last transition at phase 'ph' to the declaration,
  // for a window of 'period' phases whose activity flag clears at 'clr'
  function automatic int unsigned declare_latency(input int unsigned ph,
                                                  input int unsigned clr,
                                                  input int unsigned period);
    if (ph < clr) return (period - 1) - ph;
    return (2 * period - 1) - ph;
  endfunction

  // next value of a saturating count
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

endpackage

// File: rtl/los_window_ctr.sv
`timescale 1ns/1ps
module los_window_ctr #(
  parameter int unsigned CNT_W    = 7,
  parameter int unsigned CLEAR_AT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] phase_o,
  output logic             eval_o,
  output logic             clear_o
);
  localparam logic [CNT_W-1:0] LAST_PH  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CLEAR_PH = CNT_W'(CLEAR_AT);

  logic [CNT_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_q + 1'b1;
  end

  assign phase_o = phase_q;
  assign eval_o  = (phase_q == LAST_PH);
  assign clear_o = (phase_q == CLEAR_PH);

  // R6: evaluation points recur every full window, the counter wraps to zero
  a_r6_phase_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    eval_o |=> (phase_o == '0));

endmodule

// File: rtl/los_squelch_edge.sv
`timescale 1ns/1ps
module los_squelch_edge #(
  parameter logic SQ_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic data_i,
  input  logic force_i,
  output logic data_o,
  output logic trans_o
);
  logic prev_q;

  assign data_o  = force_i ? SQ_LEVEL : data_i;
  assign trans_o = (data_o != prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= SQ_LEVEL;
    else        prev_q <= data_o;
  end

  // R3: once force has been held for a full bit, the squelched stream is flat
  a_r3_no_edge_under_force: assert property (@(posedge clk) disable iff (!rst_n)
    (force_i && $past(force_i)) |-> !trans_o);

endmodule

// File: rtl/los_activity_flag.sv
`timescale 1ns/1ps
module los_activity_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic trans_i,
  output logic hit_o
);
  logic seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       seen_q <= 1'b0;
    else if (clear_i) seen_q <= trans_i;
    else              seen_q <= seen_q | trans_i;
  end

  // the transition of the evaluation bit itself also counts
  assign hit_o = seen_q | trans_i;

  // R8: a transition is always remembered into the next bit
  a_r8_edge_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    trans_i |=> hit_o);

endmodule

// File: rtl/los_decide.sv
`timescale 1ns/1ps
module los_decide
  import los_mon_pkg::*;
#(
  parameter int unsigned GOOD_WIN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic eval_i,
  input  logic hit_i,
  input  logic force_i,
  output logic los_o,
  output logic ref_sel_o
);
  localparam int unsigned GW = (GOOD_WIN < 2) ? 1 : $clog2(GOOD_WIN + 1);
  localparam logic [GW-1:0] GOOD_LAST = GW'(GOOD_WIN - 1);

  logic          los_q;
  logic [GW-1:0] good_q;
  ref_src_e      src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      los_q  <= 1'b1;
      good_q <= '0;
    end else if (eval_i) begin
      if (force_i) begin
        los_q  <= 1'b1;
        good_q <= '0;
      end else if (!los_q) begin
        if (!hit_i) begin
          los_q  <= 1'b1;
          good_q <= '0;
        end
      end else if (hit_i) begin
        if (good_q == GOOD_LAST) begin
          los_q  <= 1'b0;
          good_q <= '0;
        end else begin
          good_q <= good_q + 1'b1;
        end
      end else begin
        good_q <= '0;
      end
    end
  end

  assign src       = los_q ? SRC_LOCAL : SRC_DATA;
  assign los_o     = los_q;
  assign ref_sel_o = src;

  // R6: status holds between evaluation points
  a_r6_stable_mid_window: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_i |=> $stable(los_o));

  // R4: force seen at an evaluation point always declares
  a_r4_force_declares: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && force_i) |=> los_o);

  // R7: recovery never happens while force is requested
  a_r7_no_clear_under_force: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los_o) |-> !$past(force_i));

  // R7: recovery needs an active window at the clearing point
  a_r7_clear_needs_activity: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los_o) |-> $past(hit_i));

endmodule

// File: rtl/los_monitor.sv
`timescale 1ns/1ps
module los_monitor
  import los_mon_pkg::*;
#(
  parameter int unsigned CNT_W    = 7,
  parameter int unsigned CLEAR_AT = 32,
  parameter int unsigned GOOD_WIN = 2,
  parameter logic        SQ_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_in,
  input  logic force_los,
  output logic ser_out,
  output logic los_flag,
  output logic ref_sel
);
  localparam int unsigned PERIOD  = 1 << CNT_W;
  localparam int unsigned MIN_LAT = declare_latency(CLEAR_AT - 1, CLEAR_AT, PERIOD);
  localparam int unsigned MAX_LAT = declare_latency(CLEAR_AT, CLEAR_AT, PERIOD);
  localparam int unsigned QW      = $clog2(MAX_LAT + 2);

  logic [CNT_W-1:0] phase;
  logic             eval_pt;
  logic             clear_pt;
  logic             sq_data;
  logic             edge_seen;
  logic             win_hit;

  los_window_ctr #(.CNT_W(CNT_W), .CLEAR_AT(CLEAR_AT)) u_ctr (
    .clk(clk), .rst_n(rst_n), .phase_o(phase), .eval_o(eval_pt), .clear_o(clear_pt)
  );

  los_squelch_edge #(.SQ_LEVEL(SQ_LEVEL)) u_sq (
    .clk(clk), .rst_n(rst_n), .data_i(ser_in), .force_i(force_los),
    .data_o(sq_data), .trans_o(edge_seen)
  );

  los_activity_flag u_flag (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_pt), .trans_i(edge_seen), .hit_o(win_hit)
  );

  los_decide #(.GOOD_WIN(GOOD_WIN)) u_dec (
    .clk(clk), .rst_n(rst_n), .eval_i(eval_pt), .hit_i(win_hit), .force_i(force_los),
    .los_o(los_flag), .ref_sel_o(ref_sel)
  );

  assign ser_out = sq_data;

  // checker state: bits since the last transition, saturating
  logic [QW-1:0] quiet_q;
  always_ff @(posedge clk) begin
    if (!rst_n)         quiet_q <= '0;
    else if (edge_seen) quiet_q <= '0;
    else                quiet_q <= QW'(sat_inc(int'(quiet_q), MAX_LAT + 1));
  end

  // R2: a natural declaration lands inside the latency range
  a_r2_latency_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_pt && !los_flag && !win_hit && !force_los) |->
      ((int'(quiet_q) + 1 >= MIN_LAT) && (int'(quiet_q) + 1 <= MAX_LAT)));

  // R5: the reference choice always mirrors the loss status
  a_r5_ref_tracks_los: assert property (@(posedge clk) disable iff (!rst_n)
    ref_sel == los_flag);

  // R4: no edges come through once force has been held for a bit
  a_r4_phase_used: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_pt && $past(force_los) && force_los) |-> !edge_seen);

endmodule

// File: tb/los_monitor_tb.sv
`timescale 1ns/1ps
module los_monitor_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_in = 1'b0;
  logic force_los = 1'b0;
  logic ser_out, los_flag, ref_sel;

  int n_checks = 0;
  int n_errors = 0;
  int pc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  always @(posedge clk) begin
    if (!rst_n) pc <= 0;
    else        pc <= pc + 1;
  end

  los_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .force_los(force_los),
    .ser_out(ser_out), .los_flag(los_flag), .ref_sel(ref_sel)
  );

  // segment encoding: [10] force, [9:8] mode (0 hold, 1 toggle every bit,
  // 2 single toggle at phase pos), [7:1] pos, [0] expected loss flag
  function automatic logic [10:0] seg(input logic f, input logic [1:0] m,
                                      input logic [6:0] p, input logic e);
    return {f, m, p, e};
  endfunction

  localparam int NSEG = 14;
  localparam logic [10:0] SEGS [NSEG] = '{
    seg(1'b0, 2'd1, 7'd0,   1'b1),  // R7 one active window is not enough
    seg(1'b0, 2'd1, 7'd0,   1'b0),  // R7 second active window clears
    seg(1'b1, 2'd1, 7'd0,   1'b1),  // R4 force declares despite toggling
    seg(1'b1, 2'd1, 7'd0,   1'b1),  // R7 held force blocks recovery
    seg(1'b0, 2'd1, 7'd0,   1'b1),  // R7 first good window after force
    seg(1'b0, 2'd0, 7'd0,   1'b1),  // R7 silent window restarts count
    seg(1'b0, 2'd1, 7'd0,   1'b1),
    seg(1'b0, 2'd1, 7'd0,   1'b0),
    seg(1'b0, 2'd0, 7'd0,   1'b1),  // R2 silent window declares
    seg(1'b0, 2'd2, 7'd64,  1'b1),
    seg(1'b0, 2'd2, 7'd10,  1'b1),  // R8 early edge does not count
    seg(1'b0, 2'd2, 7'd100, 1'b1),
    seg(1'b0, 2'd2, 7'd32,  1'b0),  // R8 edge at phase 32 counts
    seg(1'b0, 2'd2, 7'd31,  1'b1)   // R8 edge at phase 31 missed
  };

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    force_los = 1'b0;
    ser_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // clear loss, make the last transition at phase c, then time the declaration
  task automatic measure(input int c, input int exp, input string tag);
    int k;
    forever begin
      if (!los_flag && (pc % 128) == c) begin
        ser_in = ~ser_in;
        step();
        break;
      end
      ser_in = ~ser_in;
      step();
    end
    k = 0;
    while (!los_flag && k < 400) begin
      step();
      k++;
    end
    check(tag, k, exp);
  endtask

  initial begin
    int k;
    do_reset();
    // R1 reset state
    check("R1 los after reset", los_flag, 1);
    check("R1 ref_sel after reset", ref_sel, 1);
    step();
    check("R1 los before first evaluation", los_flag, 1);
    do_reset();

    // table walk, each segment is exactly one window starting at phase 0
    for (int s = 0; s < NSEG; s++) begin
      logic [10:0] e;
      e = SEGS[s];
      force_los = e[10];
      for (int i = 0; i < 128; i++) begin
        if (e[9:8] == 2'd1 || (e[9:8] == 2'd2 && i == int'(e[7:1]))) ser_in = ~ser_in;
        step();
      end
      check($sformatf("R7/R8 seg %0d los", s), los_flag, e[0]);
      check($sformatf("R5 seg %0d ref_sel", s), ref_sel, e[0]);
      check($sformatf("R3 seg %0d ser_out", s), ser_out, e[10] ? 0 : ser_in);
    end
    force_los = 1'b0;

    // R2 latency corners
    do_reset();
    measure(31,  96,  "R2 latency phase 31");
    measure(32,  223, "R2 latency phase 32");
    measure(127, 128, "R2 latency phase 127");
    measure(0,   127, "R2 latency phase 0");

    // R6 status changes only at phase 127: declaration edge is phase 127
    check("R6 declare at phase 127", (pc - 1) % 128, 127);

    // R4 force latency from phase 5
    while (los_flag) begin ser_in = ~ser_in; step(); end
    while ((pc % 128) != 5) begin ser_in = ~ser_in; step(); end
    force_los = 1'b1;
    ser_in = ~ser_in;
    step();
    k = 0;
    while (!los_flag && k < 400) begin ser_in = ~ser_in; step(); k++; end
    check("R4 force latency from phase 5", k, 122);
    check("R5 ref_sel local under force", ref_sel, 1);
    ser_in = 1'b1;
    #1;
    check("R3 ser_out squelched", ser_out, 0);
    ser_in = 1'b0;
    #1;
    check("R3 ser_out squelched low", ser_out, 0);

    // R7 toggling under force never clears
    for (int i = 0; i < 384; i++) begin ser_in = ~ser_in; step(); end
    check("R7 held force keeps loss", los_flag, 1);
    while ((pc % 128) != 0) begin ser_in = ~ser_in; step(); end
    force_los = 1'b0;
    ser_in = 1'b1;
    #1;
    check("R3 ser_out passes data", ser_out, 1);
    for (int i = 0; i < 128; i++) begin ser_in = ~ser_in; step(); end
    check("R7 one window after release", los_flag, 1);
    for (int i = 0; i < 128; i++) begin ser_in = ~ser_in; step(); end
    check("R7 two windows after release", los_flag, 0);
    check("R5 ref_sel data after clear", ref_sel, 0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule